// File: doc/BRIEF.md
# Single-Input Inversion Search for Lookup Tables

This block takes the contents of a lookup table with up to six inputs, plus a mask saying which inputs the table really uses. It searches for one input and one polarity such that inverting every table entry on that side of the input makes the table as lopsided as possible: mostly zeros, or mostly ones. A lopsided table can be stored twice and the two copies combined with AND or OR. That combination hides single-bit upsets in the majority value.

The search visits the unchanged table first. It then visits each used input in ascending order, with polarity 0 tried before polarity 1, and spends one clock on every step. The result is reported when `done` pulses:

- the table after the winning inversion;
- the input and polarity that were inverted, which tell downstream logic how to XOR the original function back;
- a flag that shows the unchanged table was kept;
- the combine select: 0 means AND, 1 means OR.

Top module: `lrs_engine`

## Requirements
- R1: After reset, `done` is 0, `tbl_out` is all zeros, `no_change` is 1, `sel_idx` is 0, `sel_pol` is 0 and `cin_sel` is 0.
- R2: The table is addressed by the binary value of the input vector, with input 0 as the least significant bit. The candidate for input k and polarity p inverts exactly the entries whose index bit k equals p, which is half of all entries. The emitted table is the winning candidate, or the unchanged table.
- R3: A candidate's score is max(zeros, ones), counted only over used entries. Used entries are the indices that have a 0 in every unused input's bit position. The winning candidate has the highest score of all candidates.
- R4: The unchanged table is scored first. Candidates follow in order of ascending input index, with polarity 0 before polarity 1. A candidate replaces the current best only when its score is strictly greater, so ties keep the earlier one.
- R5: An input whose mask bit is 0 is never selected.
- R6: When no candidate beats the unchanged table, `no_change` is 1, `tbl_out` equals the input table, and `sel_idx` and `sel_pol` are 0.
- R7: `cin_sel` is 0 when the emitted table has more zeros than ones among the used entries, and 1 otherwise.
- R8: `done` is a one-cycle pulse. It arrives no later than 2×NIN+2 clock edges after the edge that accepts `start`.
- R9: A `start` raised while a search is running is ignored, and the running search finishes on its own table.
- R10: All result outputs hold their values from one `done` pulse until the next search updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search on `tbl_in` and `use_mask`; accepted only when idle |
| tbl_in | input | 2**NIN | Table contents; bit i is the entry for input vector i |
| use_mask | input | NIN | Bit k set when input k is used |
| done | output | 1 | One-cycle pulse when the results are valid |
| tbl_out | output | 2**NIN | Restructured table |
| sel_idx | output | clog2(NIN) | Inverted input index |
| sel_pol | output | 1 | 0: the input's 0-side was inverted; 1: the input's 1-side was inverted |
| no_change | output | 1 | Unchanged table was kept |
| cin_sel | output | 1 | Combine select: 0 selects AND, 1 selects OR |

## Verification
A wrong candidate counter or a wrong polarity decode shows up at the next `done`. The emitted table then differs from the one-bit-column inversion that the requirements predict, or the selected index points at a masked input. A bad best-score register shows up as a later-tying or lower-scoring candidate replacing the right one. Directed tables with forced ties and fully masked tables expose that in a single search. A stuck state machine shows up as a missing `done` pulse or one that comes late, at most 2×NIN+2 edges after `start`.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } lrs_state_e;

    typedef struct packed {
        logic none;
        logic pol;
        logic cin;
    } lrs_flags_t;

    // Entry is inside the used portion when all unused input bits are 0.
    function automatic logic entry_used(int unsigned idx, int unsigned mask);
        return (idx & ~mask) == 0;
    endfunction

    // Entry lies on side pol of input k.
    function automatic logic side_hit(int unsigned idx, int unsigned k, logic pol);
        return logic'((idx >> k) & 1) == pol;
    endfunction

endpackage

// File: rtl/lrs_cand_gen.sv
module lrs_cand_gen #(
    parameter int NIN = 6,
    localparam int ENT = 1 << NIN,
    localparam int IW  = (NIN > 1) ? $clog2(NIN) : 1
) (
    input  logic [ENT-1:0] base,
    input  logic           en,
    input  logic [IW-1:0]  k,
    input  logic           pol,
    output logic [ENT-1:0] cand
);
    for (genvar i = 0; i < ENT; i++) begin : g_ent
        always_comb begin
            cand[i] = base[i] ^ (en & lrs_pkg::side_hit(i, 32'(k), pol));
        end
    end
endmodule

// File: rtl/lrs_scorer.sv
module lrs_scorer #(
    parameter int NIN = 6,
    localparam int ENT = 1 << NIN,
    localparam int SW  = NIN + 1
) (
    input  logic [ENT-1:0] tbl,
    input  logic [NIN-1:0] mask,
    output logic [SW-1:0]  ones,
    output logic [SW-1:0]  zeros,
    output logic [SW-1:0]  score
);
    logic [ENT-1:0] used_v;
    logic [SW-1:0]  used_n;

    for (genvar i = 0; i < ENT; i++) begin : g_used
        always_comb used_v[i] = lrs_pkg::entry_used(i, 32'(mask));
    end

    always_comb begin
        ones   = SW'($countones(tbl & used_v));
        used_n = SW'($countones(used_v));
        zeros  = used_n - ones;
        score  = (ones > zeros) ? ones : zeros;
    end
endmodule

// File: rtl/lrs_engine.sv
module lrs_engine #(
    parameter int NIN = 6,
    localparam int ENT = 1 << NIN,
    localparam int IW  = (NIN > 1) ? $clog2(NIN) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [ENT-1:0] tbl_in,
    input  logic [NIN-1:0] use_mask,
    output logic           done,
    output logic [ENT-1:0] tbl_out,
    output logic [IW-1:0]  sel_idx,
    output logic           sel_pol,
    output logic           no_change,
    output logic           cin_sel
);
    import lrs_pkg::*;

    localparam int LASTC = 2 * NIN;
    localparam int CW    = $clog2(LASTC + 1);
    localparam int SW    = NIN + 1;

    lrs_state_e     st;
    logic [CW-1:0]  cand;
    logic [CW-1:0]  cand_m1;
    logic [ENT-1:0] base_q;
    logic [NIN-1:0] mask_q;
    logic [IW-1:0]  cur_k;
    logic           cur_pol;
    logic           is_orig;
    logic           cur_used;
    logic [ENT-1:0] cand_tbl;
    logic [SW-1:0]  c_ones, c_zeros, c_score;
    logic [SW-1:0]  best_score;
    logic [ENT-1:0] best_tbl;
    logic [IW-1:0]  best_idx;
    lrs_flags_t     best_f;
    logic           take;

    always_comb begin
        is_orig  = (cand == '0);
        cand_m1  = cand - CW'(1);
        cur_k    = IW'(cand_m1 >> 1);
        cur_pol  = cand_m1[0];
        cur_used = mask_q[cur_k];
        take     = is_orig || (cur_used && (c_score > best_score));
    end

    lrs_cand_gen #(.NIN(NIN)) u_gen (
        .base (base_q),
        .en   (!is_orig),
        .k    (cur_k),
        .pol  (cur_pol),
        .cand (cand_tbl)
    );

    lrs_scorer #(.NIN(NIN)) u_score (
        .tbl   (cand_tbl),
        .mask  (mask_q),
        .ones  (c_ones),
        .zeros (c_zeros),
        .score (c_score)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cand       <= '0;
            base_q     <= '0;
            mask_q     <= '0;
            done       <= 1'b0;
            best_tbl   <= '0;
            best_idx   <= '0;
            best_score <= '0;
            best_f     <= '{none: 1'b1, pol: 1'b0, cin: 1'b0};
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= tbl_in;
                        mask_q <= use_mask;
                        cand   <= '0;
                        st     <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (take) begin
                        best_tbl   <= cand_tbl;
                        best_score <= c_score;
                        best_idx   <= is_orig ? '0 : cur_k;
                        best_f     <= '{none: is_orig,
                                        pol:  is_orig ? 1'b0 : cur_pol,
                                        cin:  !(c_zeros > c_ones)};
                    end
                    if (cand == CW'(LASTC)) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        cand <= cand + CW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign tbl_out   = best_tbl;
    assign sel_idx   = best_idx;
    assign sel_pol   = best_f.pol;
    assign no_change = best_f.none;
    assign cin_sel   = best_f.cin;
endmodule

// File: rtl/lrs_engine_chk.sv
module lrs_engine_chk #(
    parameter int NIN = 6,
    localparam int ENT = 1 << NIN,
    localparam int IW  = (NIN > 1) ? $clog2(NIN) : 1
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [ENT-1:0] tbl_in,
    input logic [NIN-1:0] use_mask,
    input logic           done,
    input logic [ENT-1:0] tbl_out,
    input logic [IW-1:0]  sel_idx,
    input logic           sel_pol,
    input logic           no_change,
    input logic           cin_sel
);
    localparam int MAXLAT = 2 * NIN + 2;

    logic           busy;
    logic [7:0]     lat;
    logic [ENT-1:0] sh_tbl;
    logic [NIN-1:0] sh_mask;
    logic           acc;

    assign acc = start && (!busy || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            lat     <= '0;
            sh_tbl  <= '0;
            sh_mask <= '0;
        end else begin
            if (acc) begin
                sh_tbl  <= tbl_in;
                sh_mask <= use_mask;
                lat     <= '0;
            end else if (busy && lat != 8'hFF) begin
                lat <= lat + 8'd1;
            end
            if (done)          busy <= start;
            else if (acc)      busy <= 1'b1;
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(lat) <= MAXLAT));

    assert_keep_orig_R6: assert property (@(posedge clk) disable iff (rst)
        (done && no_change) |-> (tbl_out == sh_tbl && sel_idx == '0 && !sel_pol));

    assert_half_flip_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !no_change) |-> ($countones(tbl_out ^ sh_tbl) == ENT / 2));

    assert_used_input_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !no_change) |-> sh_mask[sel_idx]);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(tbl_out) && $stable(no_change) &&
                               $stable(cin_sel) && $stable(sel_idx)));
endmodule

bind lrs_engine lrs_engine_chk #(.NIN(NIN)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tbl_in    (tbl_in),
    .use_mask  (use_mask),
    .done      (done),
    .tbl_out   (tbl_out),
    .sel_idx   (sel_idx),
    .sel_pol   (sel_pol),
    .no_change (no_change),
    .cin_sel   (cin_sel)
);

// File: tb/lrs_engine_tb.sv
module lrs_engine_tb_top;
    localparam int NIN = 6;
    localparam int ENT = 1 << NIN;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [ENT-1:0] tbl_in;
    logic [NIN-1:0] use_mask;
    logic           done;
    logic [ENT-1:0] tbl_out;
    logic [2:0]     sel_idx;
    logic           sel_pol;
    logic           no_change;
    logic           cin_sel;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    lrs_engine #(.NIN(NIN)) dut_i (
        .clk(clk), .rst(rst), .start(start), .tbl_in(tbl_in),
        .use_mask(use_mask), .done(done), .tbl_out(tbl_out),
        .sel_idx(sel_idx), .sel_pol(sel_pol), .no_change(no_change),
        .cin_sel(cin_sel)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [ENT-1:0] act, input logic [ENT-1:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    function automatic int used_ones(logic [ENT-1:0] t, logic [NIN-1:0] m);
        int n = 0;
        for (int i = 0; i < ENT; i++)
            if ((i & ~int'(m)) == 0 && t[i]) n++;
        return n;
    endfunction

    function automatic int used_cnt(logic [NIN-1:0] m);
        return 1 << $countones(m);
    endfunction

    function automatic int score_of(logic [ENT-1:0] t, logic [NIN-1:0] m);
        int o = used_ones(t, m);
        int z = used_cnt(m) - o;
        return (o > z) ? o : z;
    endfunction

    // Reference search built from R2..R7.
    task automatic ref_search(input logic [ENT-1:0] t, input logic [NIN-1:0] m,
                              output logic [ENT-1:0] bt, output int bk,
                              output logic bp, output logic bn, output logic bc);
        int bs;
        bt = t; bk = 0; bp = 1'b0; bn = 1'b1;
        bs = score_of(t, m);
        for (int k = 0; k < NIN; k++) begin
            for (int p = 0; p < 2; p++) begin
                logic [ENT-1:0] c;
                c = t;
                for (int i = 0; i < ENT; i++)
                    if (((i >> k) & 1) == p) c[i] = ~c[i];
                if (m[k] && score_of(c, m) > bs) begin
                    bs = score_of(c, m); bt = c; bk = k; bp = p[0]; bn = 1'b0;
                end
            end
        end
        bc = ((used_cnt(m) - used_ones(bt, m)) > used_ones(bt, m)) ? 1'b0 : 1'b1;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input logic [ENT-1:0] t, input logic [NIN-1:0] m,
                                input int lat);
        logic [ENT-1:0] et; int ek; logic ep, en, ec;
        ref_search(t, m, et, ek, ep, en, ec);
        chk(done && lat <= 2 * NIN + 2, "R8 done latency", ENT'(lat), ENT'(2 * NIN + 2));
        chk(tbl_out == et, "R2 R3 table", tbl_out, et);
        chk(int'(sel_idx) == ek, "R4 R5 index", ENT'(sel_idx), ENT'(ek));
        chk(sel_pol == ep, "R4 polarity", ENT'(sel_pol), ENT'(ep));
        chk(no_change == en, "R6 no_change", ENT'(no_change), ENT'(en));
        chk(cin_sel == ec, "R7 cin", ENT'(cin_sel), ENT'(ec));
        @(negedge clk);
        chk(!done, "R8 single pulse", ENT'(done), '0);
    endtask

    task automatic run_job(input logic [ENT-1:0] t, input logic [NIN-1:0] m);
        int lat;
        tbl_in = t; use_mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check_result(t, m, lat);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [ENT-1:0] t, hold;
        int lat;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; start = 1'b0; tbl_in = '0; use_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done && tbl_out == '0, "R1 reset table/done", tbl_out, '0);
        chk(no_change && sel_idx == 0 && !sel_pol && !cin_sel, "R1 reset flags",
            ENT'({no_change, sel_idx, sel_pol, cin_sel}), ENT'(6'b100000));

        // Directed corners: R6 constant tables, R7 both cin values.
        run_job('0, 6'h3F);
        run_job('1, 6'h3F);
        // Entry = input 2: inversion on input 2 makes it uniform (R2, R3).
        for (int i = 0; i < ENT; i++) t[i] = i[2];
        run_job(t, 6'h07);
        // Tie on input 0: polarity 0 wins over polarity 1 (R4).
        for (int i = 0; i < ENT; i++) t[i] = i[0];
        run_job(t, 6'h01);
        // Only input 5 used; R5 masks the rest.
        for (int i = 0; i < ENT; i++) t[i] = i[5] ^ i[0];
        run_job(t, 6'h20);
        // Empty mask: single used entry, R6.
        run_job(64'hA5A5_0F0F_3C3C_1234, 6'h00);

        // R9: second start during a running search is ignored.
        t = 64'h0000_0000_0000_00F0;
        tbl_in = t; use_mask = 6'h3F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        tbl_in = '1; use_mask = 6'h01; start = 1'b1;
        @(negedge clk);
        start = 1'b0; tbl_in = '0;
        lat = 0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        lat = lat + 4;
        check_result(t, 6'h3F, lat);

        // R10: outputs hold while idle.
        hold = tbl_out;
        repeat (6) @(negedge clk);
        chk(tbl_out == hold, "R10 hold", tbl_out, hold);

        // Random tables and masks.
        for (int n = 0; n < 60; n++) begin
            t = {$urandom(), $urandom()};
            if (n % 4 == 0) t = t & {$urandom(), $urandom()} & {$urandom(), $urandom()};
            run_job(t, NIN'($urandom()));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule